// File: doc/BRIEF.md
# PCM Voice Serial Port

This block is the serial data port of a single-channel voice codec. It moves 13-bit two's complement samples between parallel registers and a serial bit stream. The transmit half runs from its own bit clock and frame sync and serialises one word per frame. The receive half runs from a separate bit clock and frame sync and turns the incoming bit stream back into a parallel word. Both bit clocks and frame syncs are sampled by a faster system clock `clk` and must already be synchronous to it. Bit clocks may run from 256 kHz to 4.8 MHz, and each bit-clock phase lasts several `clk` periods.

Each direction has a frame-sync classifier. It counts the bit-clock falling edges on which the sync is seen high. A pulse seen on exactly one falling edge is short. A pulse seen on two or more is long. The class of a pulse becomes known when the pulse ends, so it decides the timing of the following frame. In short frames the transmit output is enabled on the first rising edge after the sync and released in the middle of the last bit. In long frames it is enabled as soon as the sync qualifies and stays enabled until both the word has finished and the sync has fallen.

After reset, and after every power-down, the transmitter skips two frame syncs with its output disabled. This keeps the shared data line clear of collisions. The pad driver outside the block combines `tx_data` with `tx_oe` to form the tri-state line.

Classifier states: `FS_LOW` (no pulse in progress), `FS_FIRST` (sync seen on one falling edge), `FS_WIDE` (sync seen on two or more). Its transitions, all on a bit-clock falling edge, are:
- `FS_LOW`→`FS_FIRST` when the sync is high. This is the sync-start event.
- `FS_FIRST`→`FS_WIDE` when the sync is still high.
- `FS_FIRST`→`FS_LOW` when the sync is low. The pulse is classed short.
- `FS_WIDE`→`FS_LOW` when the sync is low. The pulse is classed long.

Transmit states: `TX_IDLE`, `TX_ARM` (word loaded, waiting for the first rising edge), `TX_SHIFT` (one bit per rising edge), `TX_HOLD` (long frame, word done, sync still high). Its transitions are:
- `TX_IDLE`→`TX_ARM` on sync-start when no blanking remains.
- `TX_ARM`→`TX_SHIFT` on a rising edge.
- `TX_SHIFT`→`TX_IDLE` on the falling edge in the last bit, unless the frame is long and the sync is still high.
- `TX_SHIFT`→`TX_HOLD` on that same falling edge when the frame is long and the sync is still high.
- `TX_HOLD`→`TX_IDLE` when the sync is low.
- Any state →`TX_IDLE` while powered down.

Receive states: `RX_IDLE` and `RX_SHIFT`. Its transitions are:
- `RX_IDLE`→`RX_SHIFT` on sync-start.
- `RX_SHIFT`→`RX_SHIFT` on a new sync-start. The bit count restarts.
- `RX_SHIFT`→`RX_IDLE` after the 13th sampled bit.
- Any state →`RX_IDLE` while powered down.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, `tx_oe` and `rx_valid` are 0, `tx_blank` is 1, and `tx_long` and `rx_long` are 0 (short).
- R2: A sync pulse seen high on exactly one bit-clock falling edge sets the mode output (`tx_long` or `rx_long`) to 0. A pulse seen high on two or more falling edges sets it to 1. The update happens on the first falling edge that sees the sync low.
- R3: Whether a frame uses short or long timing is decided by the class of the previous sync pulse, not the current one.
- R4: `tx_word` is latched at the falling edge where the sync first reads high. Its bit 12 (the sign bit) is sent first, on the next rising edge. Each following rising edge sends the next lower bit, for 13 bits in all.
- R5: In a short frame, `tx_oe` rises with the first data rising edge. It falls after the bit-clock falling edge in the middle of bit 0.
- R6: In a long frame, `tx_oe` rises right after the falling edge where the sync first reads high, driving bit 12. It stays high through the middle-of-bit-0 falling edge if the sync is still high, and drops once the sync is low.
- R7: The receiver takes `rx_data` on each of the 13 falling edges that follow the sync-start falling edge, most significant bit first. It then presents the word on `rx_word` with `rx_valid` high for exactly one `clk` cycle.
- R8: After reset or power-down, the first two transmit syncs produce no output. `tx_blank` stays 1 until the second of those syncs. The third frame transmits normally.
- R9: While `pwr_up` is 0, `tx_oe` is 0 from the next `clk` cycle, and any frame in progress is abandoned.
- R10: The long-pulse width may differ from frame to frame (2, 3 or 16 bit periods). Each still classes as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all port signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up | input | 1 | 1 = operating, 0 = powered down |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_word | input | 13 | Parallel sample to transmit, two's complement |
| tx_data | output | 1 | Serial transmit bit |
| tx_oe | output | 1 | Output enable for the tri-state transmit pad |
| tx_blank | output | 1 | Collision-avoidance blanking active |
| tx_long | output | 1 | Class of the last transmit sync (1 = long) |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial receive bit |
| rx_word | output | 13 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| rx_long | output | 1 | Class of the last receive sync (1 = long) |

## Verification
Every bit-clock edge is seen one `clk` cycle after the port changes, and each state register adds one more cycle. So `tx_oe`, `tx_data` and the mode outputs settle within two cycles of the edge that moves them, and `rx_valid` pulses one cycle after the 13th sampling edge. The bench holds each bit-clock phase for four `clk` cycles and reads the outputs on the third negative clock edge of a phase, after the registers have settled and before the next edge. Strobes are counted by a monitor on every cycle rather than sampled. The power-down response is read two cycles after `pwr_up` falls.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    localparam int SAMPLE_W = 13;

    typedef enum logic [1:0] {
        FS_LOW,
        FS_FIRST,
        FS_WIDE
    } fs_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARM,
        TX_SHIFT,
        TX_HOLD
    } tx_state_t;

    typedef enum logic {
        RX_IDLE,
        RX_SHIFT
    } rx_state_t;
endpackage

// File: rtl/pcm_fs_detect.sv
module pcm_fs_detect
    import pcm_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fs,
    output logic bclk_fall,
    output logic sync_start,
    output logic mode_long
);
    fs_state_t state, state_nx;
    logic      bclk_q;
    logic      mode_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            state     <= FS_LOW;
            mode_long <= 1'b0;
        end else begin
            bclk_q    <= bclk;
            state     <= state_nx;
            mode_long <= mode_nx;
        end
    end

    assign bclk_fall  = bclk_q & ~bclk;
    assign sync_start = bclk_fall & fs & (state == FS_LOW);

    always_comb begin
        state_nx = state;
        mode_nx  = mode_long;
        if (bclk_fall) begin
            unique case (state)
                FS_LOW:   if (fs) state_nx = FS_FIRST;
                FS_FIRST: begin
                    if (fs) begin
                        state_nx = FS_WIDE;
                    end else begin
                        state_nx = FS_LOW;
                        mode_nx  = 1'b0;
                    end
                end
                FS_WIDE: begin
                    if (!fs) begin
                        state_nx = FS_LOW;
                        mode_nx  = 1'b1;
                    end
                end
                default:  state_nx = FS_LOW;
            endcase
        end
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
    import pcm_port_pkg::*;
#(
    parameter int WORD_W       = SAMPLE_W,
    parameter int BLANK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up,
    input  logic              bclk,
    input  logic              bclk_fall,
    input  logic              sync_start,
    input  logic              fs,
    input  logic              mode_long,
    input  logic [WORD_W-1:0] word,
    output logic              data,
    output logic              oe,
    output logic              blank
);
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int BLANK_W = $clog2(BLANK_FRAMES + 1);
    localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(WORD_W - 1);
    localparam logic [BLANK_W-1:0] BLANK_INIT = BLANK_W'(BLANK_FRAMES);

    tx_state_t          state, state_nx;
    logic               bclk_q;
    logic               bclk_rise;
    logic [WORD_W-1:0]  shreg;
    logic [IDX_W-1:0]   bit_idx;
    logic [BLANK_W-1:0] blank_cnt;
    logic               frame_long;

    assign bclk_rise = bclk & ~bclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!pwr_up) begin
            state_nx = TX_IDLE;
        end else begin
            unique case (state)
                TX_IDLE:  if (sync_start && blank_cnt == '0) state_nx = TX_ARM;
                TX_ARM:   if (bclk_rise) state_nx = TX_SHIFT;
                TX_SHIFT: if (bclk_fall && bit_idx == LAST_IDX)
                              state_nx = (frame_long && fs) ? TX_HOLD : TX_IDLE;
                TX_HOLD:  if (!fs) state_nx = TX_IDLE;
            endcase
        end
    end

    // datapath and blanking counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q     <= 1'b0;
            shreg      <= '0;
            bit_idx    <= '0;
            blank_cnt  <= BLANK_INIT;
            frame_long <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (!pwr_up) begin
                blank_cnt <= BLANK_INIT;
            end else if (state == TX_IDLE && sync_start) begin
                shreg      <= word;
                frame_long <= mode_long;
                if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
            end else if (state == TX_ARM && bclk_rise) begin
                bit_idx <= '0;
            end else if (state == TX_SHIFT && bclk_rise && bit_idx != LAST_IDX) begin
                shreg   <= {shreg[WORD_W-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        data  = shreg[WORD_W-1];
        blank = (blank_cnt != '0);
        unique case (state)
            TX_IDLE:  oe = 1'b0;
            TX_ARM:   oe = frame_long;
            TX_SHIFT: oe = 1'b1;
            TX_HOLD:  oe = 1'b1;
        endcase
    end

    assert_blank_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !oe);

    assert_powerdown_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> !oe);

    assert_short_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SHIFT && bclk_fall && bit_idx == LAST_IDX && !frame_long) |=> !oe);
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up,
    input  logic              bclk_fall,
    input  logic              sync_start,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    rx_state_t         state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!pwr_up) begin
            state_nx = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:  if (sync_start) state_nx = RX_SHIFT;
                RX_SHIFT: if (!sync_start && bclk_fall && bit_cnt == LAST_IDX)
                              state_nx = RX_IDLE;
            endcase
        end
    end

    // outputs and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            word    <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!pwr_up) begin
                bit_cnt <= '0;
            end else if (sync_start) begin
                bit_cnt <= '0;
            end else if (state == RX_SHIFT && bclk_fall) begin
                shreg   <= {shreg[WORD_W-2:0], din};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_IDX) begin
                    word  <= {shreg[WORD_W-2:0], din};
                    valid <= 1'b1;
                end
            end
        end
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SHIFT) |-> (bit_cnt <= LAST_IDX));
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W       = SAMPLE_W,
    parameter int BLANK_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up,
    input  logic              tx_bclk,
    input  logic              tx_fs,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_data,
    output logic              tx_oe,
    output logic              tx_blank,
    output logic              tx_long,
    input  logic              rx_bclk,
    input  logic              rx_fs,
    input  logic              rx_data,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_long
);
    logic tx_fall, tx_sync;
    logic rx_fall, rx_sync;

    pcm_fs_detect u_tx_fs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (tx_bclk),
        .fs         (tx_fs),
        .bclk_fall  (tx_fall),
        .sync_start (tx_sync),
        .mode_long  (tx_long)
    );

    pcm_fs_detect u_rx_fs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (rx_bclk),
        .fs         (rx_fs),
        .bclk_fall  (rx_fall),
        .sync_start (rx_sync),
        .mode_long  (rx_long)
    );

    pcm_tx_serializer #(
        .WORD_W       (WORD_W),
        .BLANK_FRAMES (BLANK_FRAMES)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up     (pwr_up),
        .bclk       (tx_bclk),
        .bclk_fall  (tx_fall),
        .sync_start (tx_sync),
        .fs         (tx_fs),
        .mode_long  (tx_long),
        .word       (tx_word),
        .data       (tx_data),
        .oe         (tx_oe),
        .blank      (tx_blank)
    );

    pcm_rx_deserializer #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up     (pwr_up),
        .bclk_fall  (rx_fall),
        .sync_start (rx_sync),
        .din        (rx_data),
        .word       (rx_word),
        .valid      (rx_valid)
    );
endmodule

// File: tb/pcm_voice_port_bench.sv
module pcm_voice_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_up = 1'b1;
    logic         tx_bclk = 1'b0, tx_fs = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_data, tx_oe, tx_blank, tx_long;
    logic         rx_bclk = 1'b0, rx_fs = 1'b0, rx_data = 1'b0;
    logic [W-1:0] rx_word;
    logic         rx_valid, rx_long;

    int checks = 0;
    int fails  = 0;
    int valid_total = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_voice_port u_pcm_voice_port (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
        .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_word(tx_word),
        .tx_data(tx_data), .tx_oe(tx_oe), .tx_blank(tx_blank), .tx_long(tx_long),
        .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_data(rx_data),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_long(rx_long)
    );

    always @(posedge clk) if (rx_valid) valid_total <= valid_total + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit period: rising phase then falling phase, four clk cycles each
    task automatic bit_period(input logic fsv, input logic rxb,
                              output logic pre_oe, output logic pre_data, output logic post_oe);
        @(negedge clk);
        tx_bclk = 1'b1; rx_bclk = 1'b1;
        tx_fs = fsv; rx_fs = fsv; rx_data = rxb;
        repeat (3) @(negedge clk);
        pre_oe = tx_oe; pre_data = tx_data;
        @(negedge clk);
        tx_bclk = 1'b0; rx_bclk = 1'b0;
        repeat (3) @(negedge clk);
        post_oe = tx_oe;
    endtask

    task automatic run_frame(input int n_high, input logic [W-1:0] tw, input logic [W-1:0] rw,
                             input logic exp_long, input logic exp_drive, input logic nxt_long);
        int   total;
        int   v0;
        logic po, pd, qo, rb;
        total = (n_high + 2 > 16) ? n_high + 2 : 16;
        tx_word = tw;
        v0 = valid_total;
        for (int k = 0; k < total; k++) begin
            rb = (k >= 1 && k <= 13) ? rw[13-k] : 1'b0;
            bit_period(k < n_high, rb, po, pd, qo);
            if (k == 0) check("R6 oe after qualifying edge", {31'd0, qo}, {31'd0, exp_drive & exp_long});
            if (k >= 1 && k <= 13) begin
                check("R5 oe during word", {31'd0, po}, {31'd0, exp_drive});
                if (exp_drive) check("R4 serial bit", {31'd0, pd}, {31'd0, tw[13-k]});
            end
            if (k == 13)
                check("R5 R6 oe after mid-LSB edge", {31'd0, qo},
                      {31'd0, exp_drive & exp_long & (n_high > 13)});
            if (k > 13 && k < n_high)
                check("R6 oe held while sync high", {31'd0, po}, {31'd0, exp_drive & exp_long});
            if (k == n_high && n_high > 13)
                check("R6 oe off once sync low", {31'd0, po}, 32'd0);
        end
        check("R7 strobe count", valid_total - v0, 1);
        check("R7 received word", {19'd0, rx_word}, {19'd0, rw});
        check("R2 R10 tx mode", {31'd0, tx_long}, {31'd0, nxt_long});
        check("R2 rx mode", {31'd0, rx_long}, {31'd0, nxt_long});
    endtask

    task automatic test_reset();
        check("R1 tx_oe", {31'd0, tx_oe}, 32'd0);
        check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R1 tx_blank", {31'd0, tx_blank}, 32'd1);
        check("R1 tx_long", {31'd0, tx_long}, 32'd0);
        check("R1 rx_long", {31'd0, rx_long}, 32'd0);
    endtask

    task automatic test_blanking();
        run_frame(1, 13'h1234, 13'h0ABC, 1'b0, 1'b0, 1'b0);
        check("R8 blank after first sync", {31'd0, tx_blank}, 32'd1);
        run_frame(1, 13'h0321, 13'h1F0F, 1'b0, 1'b0, 1'b0);
        check("R8 blank cleared after second sync", {31'd0, tx_blank}, 32'd0);
    endtask

    task automatic test_modes();
        run_frame(1,  13'h1A5C, 13'h0F33, 1'b0, 1'b1, 1'b0);  // R4 R5 short
        run_frame(3,  13'h0AAA, 13'h1555, 1'b0, 1'b1, 1'b1);  // R3 wide pulse, short timing
        run_frame(16, 13'h1001, 13'h0001, 1'b1, 1'b1, 1'b1);  // R6 R10 long with hold
        run_frame(2,  13'h1000, 13'h1FFF, 1'b1, 1'b1, 1'b1);  // R6 R10 long, sync ends early
        run_frame(1,  13'h0555, 13'h1000, 1'b1, 1'b1, 1'b0);  // R3 narrow pulse, long timing
        run_frame(1,  13'h1FFF, 13'h0000, 1'b0, 1'b1, 1'b0);  // R5 back to short
    endtask

    task automatic test_powerdown();
        logic po, pd, qo;
        tx_word = 13'h1555;
        for (int k = 0; k < 6; k++) bit_period(k < 1, 1'b1, po, pd, qo);
        check("R9 oe before power-down", {31'd0, tx_oe}, 32'd1);
        pwr_up = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 oe off in power-down", {31'd0, tx_oe}, 32'd0);
        check("R8 blank set by power-down", {31'd0, tx_blank}, 32'd1);
        for (int k = 6; k < 16; k++) bit_period(1'b0, 1'b0, po, pd, qo);
        check("R9 oe stays off", {31'd0, tx_oe}, 32'd0);
        pwr_up = 1'b1;
        run_frame(1, 13'h0F0F, 13'h00FF, 1'b0, 1'b0, 1'b0);
        run_frame(1, 13'h1111, 13'h1EEE, 1'b0, 1'b0, 1'b0);
        check("R8 blank cleared again", {31'd0, tx_blank}, 32'd0);
        run_frame(1, 13'h0B3D, 13'h14C2, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_blanking();
        test_modes();
        test_powerdown();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule